// File: doc/BRIEF.md
# Omega Network Switch Fabric

This block joins N requesters to N targets through a pipelined multistage network. N is a power of two. The network is built from log2(N) stages, and each stage holds N/2 two-by-two switches. Ahead of every stage the lines are re-wired by a perfect shuffle: the line index is rotated left by one bit. Each switch then steers a message to its even or its odd output using a single bit of the message's destination index. The first stage uses the most significant bit, and each later stage uses the next lower bit. After the last stage a message sits on the output line whose index equals its destination, wherever it entered.

Each input line presents a valid bit, a destination index and a payload. Each output line reports a valid bit, the payload and the index of the input it came from. Two messages may need the same switch output in the same cycle. When that happens, the one on the switch's upper input goes through and the other is discarded. The discarded message's source gets a one-cycle pulse on its blocked flag. Every stage ends in a register, so a fresh set of messages can be accepted on every clock.

Top module: `omega_fabric`

## Requirements
- R1: A message that is valid on an input at a rising edge appears on the outputs right after the STAGES-th rising edge, counting the sampling edge as the first. STAGES is log2(N_PORTS). It stays valid there for one cycle only, unless another message follows it.
- R2: A delivered message appears on output line `out_valid[d]`, where d is its destination index, with its payload unchanged. Port i uses these slices: `in_dest[i*IDX_W +: IDX_W]`, `in_data[i*DATA_W +: DATA_W]`, `out_src[i*IDX_W +: IDX_W]` and `out_data[i*DATA_W +: DATA_W]`.
- R3: The `out_src` slice of a valid output line equals the index of the input that carried the message.
- R4: Within a switch, the upper input is shuffled line 2j and the lower input is shuffled line 2j+1. If both inputs are valid and their routing bits are equal, the upper message is forwarded and the lower message is discarded; it never reaches an output.
- R5: Suppose a message sampled at edge e is discarded in stage k, where k runs from 1 to STAGES. Then `blocked[src]` is high for exactly the cycle after edge e+k-1. If no discard happens, `blocked` stays low.
- R6: Lines are re-wired before every stage so that line x moves to line ((x<<1)|(x>>(STAGES-1))) mod N. Stage k routes on destination bit STAGES-k. A routing bit of 0 selects output line 2j and a bit of 1 selects line 2j+1.
- R7: A low `rst_n` at a rising edge empties the pipeline. After that edge, `out_valid` and `blocked` are all zero, and messages that were in flight never appear.
- R8: A message that is the only valid input at its sampling edge is always delivered and never flagged as blocked.
- R9: A new set of inputs may be presented on every cycle. Messages sampled at different edges never interfere with each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | N_PORTS | Per-input message present |
| in_dest | input | N_PORTS*IDX_W | Per-input destination index |
| in_data | input | N_PORTS*DATA_W | Per-input payload |
| out_valid | output | N_PORTS | Per-output message present |
| out_src | output | N_PORTS*IDX_W | Source index of each delivered message |
| out_data | output | N_PORTS*DATA_W | Payload of each delivered message |
| blocked | output | N_PORTS | One-cycle pulse per source whose message was discarded |

## Verification
The bench builds the fabric with eight ports and an 8-bit payload, which gives three stages and twelve switches. At that size every one of the 64 source and destination pairings can be streamed as a lone message. Shifted and XOR permutations, random masked patterns and hot-spot patterns that all aim at one output then force clashes in every stage. A bit-level model in the bench replays the shuffle, the routing and the upper-wins rule, so each delivered line and each blocked pulse is compared cycle by cycle while traffic streams back to back.

// File: rtl/omega_pkg.sv
// Package omega_pkg
// Shared helpers for the omega fabric. It holds the shuffle index
// computation, which is used at elaboration time to lay out wiring.
package omega_pkg;

    // Rotate an index of 'bits' bits left by one position.
    function automatic int unsigned shuffle_pos(input int unsigned line,
                                                input int unsigned bits);
        int unsigned mask;
        mask = (32'd1 << bits) - 32'd1;
        return ((line << 1) | (line >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_switch2.sv
// Module omega_switch2
// A 2x2 crossbar element. Each input message carries {dest, src, data}.
// Routing bit ROUTE_BIT of dest picks output 0 (bit clear) or output 1
// (bit set). On a clash the upper input (index 0) wins, and the lower
// message is reported as dropped. Purely combinational.
// Assumes: invalid inputs may carry any message bits.
module omega_switch2 #(
    parameter int IDX_W     = 3,
    parameter int DATA_W    = 8,
    parameter int ROUTE_BIT = 0
) (
    input  logic [1:0]                          in_v,
    input  logic [1:0][2*IDX_W+DATA_W-1:0]      in_msg,
    output logic [1:0]                          out_v,
    output logic [1:0][2*IDX_W+DATA_W-1:0]      out_msg,
    output logic                                drop_v,
    output logic [IDX_W-1:0]                    drop_src
);
    localparam int MSG_W   = 2 * IDX_W + DATA_W;
    localparam int BIT_POS = DATA_W + IDX_W + ROUTE_BIT;

    logic up_bit;
    logic lo_bit;
    logic clash;

    assign up_bit = in_msg[0][BIT_POS];
    assign lo_bit = in_msg[1][BIT_POS];
    assign clash  = in_v[0] && in_v[1] && (up_bit == lo_bit);

    // Steer both messages; the upper one has priority on a clash.
    always_comb begin
        out_v   = '0;
        out_msg = '0;
        if (in_v[0]) begin
            out_v[up_bit]   = 1'b1;
            out_msg[up_bit] = in_msg[0];
        end
        if (in_v[1] && !clash) begin
            out_v[lo_bit]   = 1'b1;
            out_msg[lo_bit] = in_msg[1];
        end
    end

    // Report the loser of a clash together with its source index.
    assign drop_v   = clash;
    assign drop_src = in_msg[1][DATA_W +: IDX_W];

    logic unused_w;
    assign unused_w = ^{MSG_W[0]};
endmodule

// File: rtl/omega_stage.sv
// Module omega_stage
// One network stage: perfect-shuffle wiring, N/2 switches and a
// pipeline register. STAGE_IDX counts from 0 at the input side. The
// routing bit is IDX_W-1-STAGE_IDX, so the MSB is used first.
// Drop reports are combinational, taken from this stage's inputs.
module omega_stage #(
    parameter int N_PORTS   = 8,
    parameter int DATA_W    = 8,
    parameter int STAGE_IDX = 0,
    parameter int IDX_W     = $clog2(N_PORTS)
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N_PORTS-1:0]                      in_v,
    input  logic [N_PORTS-1:0][2*IDX_W+DATA_W-1:0]  in_msg,
    output logic [N_PORTS-1:0]                      q_v,
    output logic [N_PORTS-1:0][2*IDX_W+DATA_W-1:0]  q_msg,
    output logic [N_PORTS/2-1:0]                    drop_v,
    output logic [N_PORTS/2-1:0][IDX_W-1:0]         drop_src
);
    localparam int HALF      = N_PORTS / 2;
    localparam int MSG_W     = 2 * IDX_W + DATA_W;
    localparam int ROUTE_BIT = IDX_W - 1 - STAGE_IDX;

    logic [N_PORTS-1:0]            sh_v;
    logic [N_PORTS-1:0][MSG_W-1:0] sh_msg;
    logic [N_PORTS-1:0]            nx_v;
    logic [N_PORTS-1:0][MSG_W-1:0] nx_msg;

    // Perfect shuffle: line x feeds line rotl(x).
    for (genvar x = 0; x < N_PORTS; x++) begin : g_shuffle
        localparam int DST = omega_pkg::shuffle_pos(x, IDX_W);
        assign sh_v[DST]   = in_v[x];
        assign sh_msg[DST] = in_msg[x];
    end

    // Switch column: switch j takes shuffled lines 2j and 2j+1.
    for (genvar j = 0; j < HALF; j++) begin : g_sw
        omega_switch2 #(
            .IDX_W    (IDX_W),
            .DATA_W   (DATA_W),
            .ROUTE_BIT(ROUTE_BIT)
        ) u_sw (
            .in_v    (sh_v[2*j+1:2*j]),
            .in_msg  (sh_msg[2*j+1:2*j]),
            .out_v   (nx_v[2*j+1:2*j]),
            .out_msg (nx_msg[2*j+1:2*j]),
            .drop_v  (drop_v[j]),
            .drop_src(drop_src[j])
        );
    end

    // Stage pipeline register; reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_v   <= '0;
            q_msg <= '0;
        end else begin
            q_v   <= nx_v;
            q_msg <= nx_msg;
        end
    end
endmodule

// File: rtl/omega_fabric.sv
// Module omega_fabric
// N_PORTS x N_PORTS pipelined omega network. Input i is tagged with
// source index i, then passes through STAGES = log2(N_PORTS) stages.
// It lands on output line dest after STAGES clock edges. Discarded
// messages pulse blocked[src] in the cycle after their stage's edge.
// Assumes: N_PORTS is a power of two, 2..64.
module omega_fabric #(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 8,
    parameter int IDX_W   = $clog2(N_PORTS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_PORTS-1:0]          in_valid,
    input  logic [N_PORTS*IDX_W-1:0]    in_dest,
    input  logic [N_PORTS*DATA_W-1:0]   in_data,
    output logic [N_PORTS-1:0]          out_valid,
    output logic [N_PORTS*IDX_W-1:0]    out_src,
    output logic [N_PORTS*DATA_W-1:0]   out_data,
    output logic [N_PORTS-1:0]          blocked
);
    localparam int STAGES = IDX_W;
    localparam int HALF   = N_PORTS / 2;
    localparam int MSG_W  = 2 * IDX_W + DATA_W;

    logic [N_PORTS-1:0]            st_v   [0:STAGES];
    logic [N_PORTS-1:0][MSG_W-1:0] st_msg [0:STAGES];
    logic [HALF-1:0]               dr_v   [0:STAGES-1];
    logic [HALF-1:0][IDX_W-1:0]    dr_src [0:STAGES-1];
    logic [N_PORTS-1:0]            blk_nxt;
    logic [N_PORTS*IDX_W-1:0]      arr_dest;

    // Build input messages: {dest, source index, payload}.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_in
        assign st_v[0][i]   = in_valid[i];
        assign st_msg[0][i] = {in_dest[i*IDX_W +: IDX_W], IDX_W'(i),
                               in_data[i*DATA_W +: DATA_W]};
    end

    // Chain of stages, each ending in a register.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        omega_stage #(
            .N_PORTS  (N_PORTS),
            .DATA_W   (DATA_W),
            .STAGE_IDX(s),
            .IDX_W    (IDX_W)
        ) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (st_v[s]),
            .in_msg  (st_msg[s]),
            .q_v     (st_v[s+1]),
            .q_msg   (st_msg[s+1]),
            .drop_v  (dr_v[s]),
            .drop_src(dr_src[s])
        );
    end

    // Collect all drop reports of this cycle into one source mask.
    always_comb begin
        blk_nxt = '0;
        for (int s = 0; s < STAGES; s++) begin
            for (int j = 0; j < HALF; j++) begin
                if (dr_v[s][j]) blk_nxt[dr_src[s][j]] = 1'b1;
            end
        end
    end

    // Register the blocked pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) blocked <= '0;
        else        blocked <= blk_nxt;
    end

    // Unpack the last stage onto the output ports.
    for (genvar i = 0; i < N_PORTS; i++) begin : g_out
        assign out_valid[i]                = st_v[STAGES][i];
        assign out_src[i*IDX_W +: IDX_W]   = st_msg[STAGES][i][DATA_W +: IDX_W];
        assign out_data[i*DATA_W +: DATA_W] = st_msg[STAGES][i][DATA_W-1:0];
        assign arr_dest[i*IDX_W +: IDX_W]  = st_msg[STAGES][i][DATA_W+IDX_W +: IDX_W];
    end
endmodule

// File: rtl/omega_fabric_chk.sv
// Module omega_fabric_chk
// Property checker for omega_fabric, attached through bind. It counts
// edges since reset so that look-back windows never reach before reset.
module omega_fabric_chk #(
    parameter int N_PORTS = 8,
    parameter int IDX_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [N_PORTS-1:0]       in_valid,
    input logic [N_PORTS-1:0]       out_valid,
    input logic [N_PORTS*IDX_W-1:0] out_src,
    input logic [N_PORTS*IDX_W-1:0] arr_dest,
    input logic [N_PORTS-1:0]       blocked
);
    localparam int STAGES = IDX_W;

    logic [3:0] cyc;

    // Count post-reset edges, saturating at STAGES.
    always_ff @(posedge clk) begin
        if (!rst_n)                cyc <= '0;
        else if (cyc < 4'(STAGES)) cyc <= cyc + 4'd1;
    end

    // R7: reset empties outputs and blocked flags.
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (out_valid == '0 && blocked == '0));

    // R1: never more deliveries than messages injected STAGES edges ago.
    a_r1_no_extra_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'(STAGES)) |->
        ($countones(out_valid) <= $countones($past(in_valid, STAGES))));

    // R8: a lone message is always delivered.
    a_r8_lone_delivered: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 4'(STAGES) && $countones($past(in_valid, STAGES)) == 1) |->
        ($countones(out_valid) == 1));

    for (genvar i = 0; i < N_PORTS; i++) begin : g_line
        // R2: a valid output line carries a message addressed to it.
        a_r2_line_matches_dest: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[i] |-> (arr_dest[i*IDX_W +: IDX_W] == IDX_W'(i)));

        // R3: the reported source was a valid input STAGES edges ago.
        a_r3_src_was_valid: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 4'(STAGES) && out_valid[i]) |->
            ((($past(in_valid, STAGES) >> out_src[i*IDX_W +: IDX_W]) & 1) != 0));
    end
endmodule

bind omega_fabric omega_fabric_chk #(
    .N_PORTS(N_PORTS),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .out_valid(out_valid),
    .out_src  (out_src),
    .arr_dest (arr_dest),
    .blocked  (blocked)
);

// File: tb/tb_omega_fabric.sv
// Bench for omega_fabric with 8 ports and 8-bit payload. Patterns are
// streamed back to back. A bit-level model of shuffle, routing and
// upper-wins arbitration predicts every output line and blocked pulse.
module tb_omega_fabric;
    localparam int N    = 8;
    localparam int DW   = 8;
    localparam int IW   = 3;
    localparam int ST   = 3;
    localparam int MAXP = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*IW-1:0] in_dest = '0;
    logic [N*DW-1:0] in_data = '0;
    logic [N-1:0]    out_valid;
    logic [N*IW-1:0] out_src;
    logic [N*DW-1:0] out_data;
    logic [N-1:0]    blocked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [N-1:0] pat_v [MAXP];
    int           pat_d [MAXP][N];
    logic [N-1:0] res_v [MAXP];
    int           res_s [MAXP][N];
    logic [N-1:0] blk_exp [MAXP+ST+1];
    int unsigned  rng = 32'h1234_5678;

    omega_fabric #(.N_PORTS(N), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_src(out_src),
        .out_data(out_data), .blocked(blocked)
    );

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] payload(input int k, input int src);
        return DW'(k * 29 + src * 11 + 3);
    endfunction

    function automatic int unsigned next_rand();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
        return rng;
    endfunction

    // Model pattern k: R4 R6 rules; drops at stage s land in blk_exp[k+s].
    task automatic model(input int k);
        int cv[N]; int cd[N]; int cs[N];
        int bv[N]; int bd[N]; int bs[N];
        for (int i = 0; i < N; i++) begin
            cv[i] = int'(pat_v[k][i]); cd[i] = pat_d[k][i]; cs[i] = i;
        end
        for (int s = 0; s < ST; s++) begin
            for (int x = 0; x < N; x++) begin
                int p;
                p = ((x << 1) | (x >> (ST - 1))) & (N - 1);
                bv[p] = cv[x]; bd[p] = cd[x]; bs[p] = cs[x];
            end
            for (int x = 0; x < N; x++) cv[x] = 0;
            for (int j = 0; j < N / 2; j++) begin
                int u; int l; int ub; int lb;
                u = 2 * j; l = 2 * j + 1;
                ub = (bd[u] >> (ST - 1 - s)) & 1;
                lb = (bd[l] >> (ST - 1 - s)) & 1;
                if (bv[u] != 0) begin
                    cv[2*j+ub] = 1; cd[2*j+ub] = bd[u]; cs[2*j+ub] = bs[u];
                end
                if (bv[l] != 0) begin
                    if (bv[u] != 0 && ub == lb) blk_exp[k+s][bs[l]] = 1'b1;
                    else begin
                        cv[2*j+lb] = 1; cd[2*j+lb] = bd[l]; cs[2*j+lb] = bs[l];
                    end
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            res_v[k][i] = (cv[i] != 0);
            res_s[k][i] = cs[i];
        end
    endtask

    task automatic drive(input int k, input bit idle);
        for (int i = 0; i < N; i++) begin
            in_valid[i]         = idle ? 1'b0 : pat_v[k][i];
            in_dest[i*IW +: IW] = idle ? '0 : IW'(pat_d[k][i]);
            in_data[i*DW +: DW] = idle ? '0 : payload(k, i);
        end
    endtask

    // Check state after edge e: outputs of pattern e-(ST-1), blocked[e].
    task automatic check_edge(input int e, input int np, input string tag);
        int k; bit bad;
        logic [N-1:0] ev;
        k = e - (ST - 1);
        ev = (k >= 0 && k < np) ? res_v[k] : '0;
        bad = (out_valid !== ev);
        for (int i = 0; i < N; i++) begin
            if (ev[i] && (out_src[i*IW +: IW] !== IW'(res_s[k][i]) ||
                          out_data[i*DW +: DW] !== payload(k, res_s[k][i])))
                bad = 1'b1;
        end
        checks++;
        if (bad) begin
            errors++;
            $display("FAIL %s edge %0d: valid=%b src=%h data=%h expected valid=%b",
                     tag, e, out_valid, out_src, out_data, ev);
        end
        checks++;
        if (blocked !== blk_exp[e]) begin
            errors++;
            $display("FAIL R5 edge %0d: blocked=%b expected %b", e, blocked, blk_exp[e]);
        end
    endtask

    // Stream np patterns back to back (R9), then drain the pipeline.
    task automatic run_burst(input int np, input string tag);
        for (int e = 0; e < MAXP + ST + 1; e++) blk_exp[e] = '0;
        for (int k = 0; k < np; k++) model(k);
        for (int c = 0; c <= np + ST; c++) begin
            @(negedge clk);
            if (c > 0) check_edge(c - 1, np, tag);
            drive(c, c >= np);
            @(posedge clk);
        end
    endtask

    initial begin
        // R7: reset with traffic on the inputs.
        for (int i = 0; i < N; i++) begin
            in_valid[i] = 1'b1; in_dest[i*IW +: IW] = IW'(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== '0 || blocked !== '0) begin
            errors++;
            $display("FAIL R7 reset: valid=%b blocked=%b expected 0 0", out_valid, blocked);
        end
        in_valid = '0;
        rst_n = 1'b1;

        // Lone messages, every pair: R1 R2 R3 R8.
        for (int p = 0; p < 64; p++) begin
            pat_v[p] = '0;
            for (int i = 0; i < N; i++) pat_d[p][i] = 0;
            pat_v[p][p/8] = 1'b1;
            pat_d[p][p/8] = p % 8;
        end
        run_burst(64, "R1 R2 R3 R8");

        // Full shift and XOR permutations: R2 R3 R6.
        for (int p = 0; p < 16; p++) begin
            pat_v[p] = '1;
            for (int i = 0; i < N; i++)
                pat_d[p][i] = (p < 8) ? (i + p) % N : (i ^ (p - 8));
        end
        run_burst(16, "R2 R3 R6");

        // Random masks and destinations: R4 R5 R9.
        for (int p = 0; p < 48; p++) begin
            pat_v[p] = N'(next_rand());
            for (int i = 0; i < N; i++) pat_d[p][i] = int'(next_rand() % N);
        end
        run_burst(48, "R4 R5 R9");

        // Hot spot: all inputs aim at one output: R4 R5.
        for (int p = 0; p < 8; p++) begin
            pat_v[p] = '1;
            for (int i = 0; i < N; i++) pat_d[p][i] = p;
        end
        run_burst(8, "R4 R5");

        // R7: reset in mid-flight drops in-flight messages.
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            in_valid[i] = 1'b1; in_dest[i*IW +: IW] = IW'(i);
        end
        @(negedge clk);
        in_valid = '0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < ST + 1; c++) begin
            checks++;
            if (out_valid !== '0 || blocked !== '0) begin
                errors++;
                $display("FAIL R7 flush cycle %0d: valid=%b blocked=%b expected 0 0",
                         c, out_valid, blocked);
            end
            @(negedge clk);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule